// File: doc/BRIEF.md
# Four-Port to Wide-Port Registered Router

This block carries the upstream direction of a bidirectional routing fabric. Four 9-bit side ports, named A, B and C and D, each feed an input register of their own. The X side can take data from one of three sources: the live port data, those input registers, or the output registers of the opposite (downstream) direction, which the block reads back. A two-bit select routes one of the four ports to port X. A one-bit select routes port B or port D to port Y.

Control inputs arrive already staged from a neighbouring block. Each of X and Y leaves as a value plus a drive enable, and the pad drivers that use them lie outside the block. Port inputs stay live while their own port drives, so a port's own driven value can be fed back and observed through the transparent path.

Top module: `quad_wide_router`

## Requirements
- R1: After an asynchronous active-low reset, all four input registers hold zero, so registered mode shows 0 on X and Y.
- R2: On a rising clock edge where load bit i is high (bit 0 = A, 1 = B, 2 = C, 3 = D), input register i captures its own port's data and nothing else.
- R3: On a rising clock edge where load bit i is low, input register i keeps its value.
- R4: With source mode 2'b00 (transparent), X and Y show live port data in the same cycle, with no register on the path.
- R5: With source mode 2'b01 (registered), X and Y show the selected input register.
- R6: With source mode 2'b10 (readback), X and Y show the selected reverse-direction output register (readback inputs rb_a..rb_d).
- R7: Source mode 2'b11 behaves exactly like registered mode.
- R8: X select 2'b00 picks A, 2'b01 picks B, 2'b10 picks C and 2'b11 picks D.
- R9: Y select 0 picks B and 1 picks D.
- R10: In transparent mode a port's register can load in the same edge. X keeps showing live data, and the loaded value appears when the mode later changes to registered.
- R11: x_oe and y_oe follow x_drive and y_drive. The drive inputs do not change the routed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the input registers, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | W | Port A data |
| b_in | input | W | Port B data |
| c_in | input | W | Port C data |
| d_in | input | W | Port D data |
| load_en | input | 4 | Input-register load enables, bit 0 = A to bit 3 = D |
| rb_a | input | W | Reverse-direction output register A |
| rb_b | input | W | Reverse-direction output register B |
| rb_c | input | W | Reverse-direction output register C |
| rb_d | input | W | Reverse-direction output register D |
| src_mode | input | 2 | Source: 00 live, 01 registered, 10 readback, 11 registered |
| x_sel | input | 2 | Port X select: 00 A, 01 B, 10 C, 11 D |
| y_sel | input | 1 | Port Y select: 0 B, 1 D |
| x_drive | input | 1 | Drive request for X |
| y_drive | input | 1 | Drive request for Y |
| x_out | output | W | Port X value |
| x_oe | output | 1 | Port X drive enable |
| y_out | output | W | Port Y value |
| y_oe | output | 1 | Port Y drive enable |

## Verification
A register load and a transparent read of the same port can fall in the same cycle. The X side must then show the live value while the register captures it. The bench provokes this by asserting a load with mode 00. It checks the live value at once, then switches to registered mode with loads off and expects the captured word. Random cycles mix loads with all four modes and both selects, so loads and reads of one register also meet in registered mode, where the new value must appear only after the edge.

// File: rtl/quad_wide_router.sv
module quad_wide_router #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] c_in,
  input  logic [W-1:0] d_in,
  input  logic [3:0]   load_en,
  input  logic [W-1:0] rb_a,
  input  logic [W-1:0] rb_b,
  input  logic [W-1:0] rb_c,
  input  logic [W-1:0] rb_d,
  input  logic [1:0]   src_mode,
  input  logic [1:0]   x_sel,
  input  logic         y_sel,
  input  logic         x_drive,
  input  logic         y_drive,
  output logic [W-1:0] x_out,
  output logic         x_oe,
  output logic [W-1:0] y_out,
  output logic         y_oe
);

  localparam int NP = 4;

  logic [W-1:0] live [NP];
  logic [W-1:0] rb   [NP];
  logic [W-1:0] ir   [NP];
  logic [W-1:0] src  [NP];

  assign live[0] = a_in;
  assign live[1] = b_in;
  assign live[2] = c_in;
  assign live[3] = d_in;
  assign rb[0]   = rb_a;
  assign rb[1]   = rb_b;
  assign rb[2]   = rb_c;
  assign rb[3]   = rb_d;

  for (genvar i = 0; i < NP; i++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ir[i] <= '0;
      else if (load_en[i]) ir[i] <= live[i];
    end

    assign src[i] = (src_mode == 2'b00) ? live[i] :
                    (src_mode == 2'b10) ? rb[i]   : ir[i];
  end

  assign x_out = src[x_sel];
  assign y_out = y_sel ? src[3] : src[1];
  assign x_oe  = x_drive;
  assign y_oe  = y_drive;

endmodule

// File: rtl/quad_wide_router_chk.sv
module quad_wide_router_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] c_in,
  input logic [W-1:0] d_in,
  input logic [3:0]   load_en,
  input logic [W-1:0] rb_b,
  input logic [W-1:0] rb_d,
  input logic [1:0]   src_mode,
  input logic [1:0]   x_sel,
  input logic         y_sel,
  input logic         x_drive,
  input logic [W-1:0] x_out,
  input logic         x_oe,
  input logic [W-1:0] y_out,
  input logic [W-1:0] ir0,
  input logic [W-1:0] ir1,
  input logic [W-1:0] ir2,
  input logic [W-1:0] ir3
);

  assert_load_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en[0] |=> ir0 == $past(a_in));
  assert_load_d_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en[3] |=> ir3 == $past(d_in));
  assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en[1] |=> $stable(ir1));
  assert_hold_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en[2] |=> $stable(ir2));
  assert_live_x_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == 2'b00 && x_sel == 2'b10) |-> x_out == c_in);
  assert_reg_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == 2'b01 && !y_sel) |-> y_out == ir1);
  assert_readback_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == 2'b10 && y_sel) |-> y_out == rb_d);
  assert_mode3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == 2'b11 && x_sel == 2'b00) |-> x_out == ir0);
  assert_live_y_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == 2'b00 && !y_sel) |-> y_out == b_in);
  assert_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    x_oe == x_drive);

endmodule

bind quad_wide_router quad_wide_router_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
  .load_en(load_en), .rb_b(rb_b), .rb_d(rb_d),
  .src_mode(src_mode), .x_sel(x_sel), .y_sel(y_sel), .x_drive(x_drive),
  .x_out(x_out), .x_oe(x_oe), .y_out(y_out),
  .ir0(ir[0]), .ir1(ir[1]), .ir2(ir[2]), .ir3(ir[3])
);

// File: tb/quad_wide_router_bench.sv
module quad_wide_router_bench;
  localparam int W = 9;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = 0, b_in = 0, c_in = 0, d_in = 0;
  logic [W-1:0] rb_a = 0, rb_b = 0, rb_c = 0, rb_d = 0;
  logic [3:0] load_en = 0;
  logic [1:0] src_mode = 2'b01, x_sel = 0;
  logic y_sel = 0, x_drive = 0, y_drive = 0;
  logic [W-1:0] x_out, y_out;
  logic x_oe, y_oe;

  int tests = 0, fails = 0;
  logic [W-1:0] mreg [4];

  always #(PERIOD/2) clk = ~clk;

  quad_wide_router #(.W(W)) u_quad_wide_router (.*);

  function automatic logic [W-1:0] port_val(input int i);
    case (i)
      0: return a_in; 1: return b_in; 2: return c_in; default: return d_in;
    endcase
  endfunction

  function automatic logic [W-1:0] rb_val(input int i);
    case (i)
      0: return rb_a; 1: return rb_b; 2: return rb_c; default: return rb_d;
    endcase
  endfunction

  function automatic logic [W-1:0] expect_src(input int i);
    if (src_mode == 2'b00) return port_val(i);
    if (src_mode == 2'b10) return rb_val(i);
    return mreg[i];
  endfunction

  function automatic string mode_tag();
    case (src_mode)
      2'b00: return "R4"; 2'b01: return "R5"; 2'b10: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    check({mode_tag(), "/R8 x"}, x_out, expect_src(int'(x_sel)));
    check({mode_tag(), "/R9 y"}, y_out, expect_src(y_sel ? 3 : 1));
    check("R11 x_oe", {{(W-1){1'b0}}, x_oe}, {{(W-1){1'b0}}, x_drive});
    check("R11 y_oe", {{(W-1){1'b0}}, y_oe}, {{(W-1){1'b0}}, y_drive});
  endtask

  task automatic tick();
    @(posedge clk);
    for (int i = 0; i < 4; i++) if (load_en[i]) mreg[i] = port_val(i);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) mreg[i] = '0;
    a_in = 9'h1a1; b_in = 9'h0b2; c_in = 9'h1c3; d_in = 9'h0d4;
    #(PERIOD * 2);
    @(negedge clk);
    // R1: registers cleared after reset
    for (int s = 0; s < 4; s++) begin
      x_sel = s[1:0]; #1;
      check("R1 x after reset", x_out, '0);
    end
    rst_n = 1;
    tick();
    check("R1 y after reset", y_out, '0);

    // R8/R4 live select decode for each port
    src_mode = 2'b00;
    for (int s = 0; s < 4; s++) begin
      x_sel = s[1:0]; #1;
      check("R8 live select", x_out, port_val(s));
    end
    y_sel = 1; #1; check("R9 y picks D", y_out, d_in);
    y_sel = 0; #1; check("R9 y picks B", y_out, b_in);

    // R10: load while transparent
    a_in = 9'h155; x_sel = 0; load_en = 4'b0001; #1;
    check("R10 live during load", x_out, 9'h155);
    tick();
    load_en = 0; a_in = 9'h0aa; #1;
    check("R10 live after load", x_out, 9'h0aa);
    src_mode = 2'b01; #1;
    check("R10 captured value", x_out, 9'h155);
    src_mode = 2'b11; #1;
    check("R7 mode 11 registered", x_out, 9'h155);

    // R3: hold with load low
    c_in = 9'h1ff; x_sel = 2'b10; tick();
    check("R3 hold", x_out, mreg[2]);
    // R2: load one port only
    load_en = 4'b0100; tick(); load_en = 0; #1;
    check("R2 load C", x_out, 9'h1ff);
    x_sel = 2'b00; #1;
    check("R2 A untouched", x_out, 9'h155);

    // R6 readback directed
    src_mode = 2'b10; rb_b = 9'h123; rb_d = 9'h045; y_sel = 1; #1;
    check("R6 readback D on y", y_out, 9'h045);

    // random mix
    for (int n = 0; n < 400; n++) begin
      a_in = W'($urandom); b_in = W'($urandom); c_in = W'($urandom); d_in = W'($urandom);
      rb_a = W'($urandom); rb_b = W'($urandom); rb_c = W'($urandom); rb_d = W'($urandom);
      load_en = 4'($urandom); src_mode = 2'($urandom); x_sel = 2'($urandom);
      y_sel = 1'($urandom); x_drive = 1'($urandom); y_drive = 1'($urandom);
      #1;
      check_outputs();
      tick();
      check_outputs();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule